// File: doc/BRIEF.md
# Multiplexed External Bus Cycle Sequencer

This block produces the external bus cycles of a small 8-bit controller whose low address byte and data share one 8-bit port, with a second 8-bit port carrying the high address. It runs on the oscillator clock. A machine cycle is twelve clocks long, split into six states of two phases each. The address-latch strobe is free-running at two pulses per machine cycle. A code fetch uses each half of the machine cycle to read one byte, at the request address and at the next address, with the program-read strobe low for three clocks. A data read or write uses the whole machine cycle. In that cycle the second address-latch pulse and both program-read pulses are left out, and a six-clock read or write strobe takes their place.

A request is presented as a kind, an address, a width flag, write data and the current value of the high-port register. It is taken only on the last clock of a machine cycle, which the block flags with `req_take`. A mode input, sampled while reset is held, decides whether low code addresses come from on-chip memory. Those halves of a fetch leave the bus quiet. Read bytes are returned on `rdata` with a one-clock valid pulse.

Top module: `mxb_sequencer`

## Requirements
- R1: Clock positions 0 to 11 of a machine cycle follow reset. `ale` is high at positions 0, 1, 6 and 7 of every idle or fetch cycle and low at every other position.
- R2: In a data read or write cycle, `ale` is high only at positions 0 and 1; the pulse at positions 6 and 7 is skipped.
- R3: A fetch reads address A in its first half and A+1 in its second half. For each half that goes to the external bus, `psen_n` is low at half-offsets 3, 4 and 5, i.e. positions 3-5 and 9-11. `psen_n` is high at all other times, including idle and data cycles and on-chip halves.
- R4: The low port drives the low byte of the cycle's address, with `lo_oe` high, at offsets 0, 1 and 2 of each external fetch half and at positions 0-2 of a data cycle. `lo_oe` is low whenever `psen_n` or `rd_n` is low.
- R5: `hi_out` carries the high byte of the half's address during an external fetch half and during a data cycle with `req_wide`=1. In all other cases it carries the `p2_reg` value taken with the request, which includes data cycles with `req_wide`=0.
- R6: `rd_n` (read cycle) or `wr_n` (write cycle) is low at positions 5 to 10, which is three clocks after `ale` falls. `ale` rises again one clock after the strobe rises.
- R7: In a write cycle the low port is released at position 3 and drives `req_wdata` at positions 4 to 11, so the data is stable for seven clocks before `wr_n` rises and for one clock after it rises.
- R8: The read byte is taken from `lo_in` in the last clock that `psen_n` or `rd_n` is low (positions 5 and 11 for fetch halves, position 10 for a read). It appears on `rdata` with `rdata_valid` high for exactly one clock, in the clock that follows.
- R9: `int_rom_en` is sampled only while `rst` is high. If it was 1, a fetch half whose address is below 8192 is served on chip: no `psen_n` pulse, no low-port drive and no `rdata_valid`. If it was 0, every half goes to the bus.
- R10: `req_kind` is encoded as 0 idle, 1 fetch, 2 data read and 3 data write. `req_take` is high only at position 11, once every 12 clocks. Request inputs are sampled only at that clock, and changes at any other time have no effect.
- R11: While `rst` is high, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `lo_oe`=0 and `rdata_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| int_rom_en | input | 1 | On-chip code enable, sampled during reset |
| req_kind | input | 2 | Request kind: 0 idle, 1 fetch, 2 read, 3 write |
| req_wide | input | 1 | Data access uses a 16-bit address |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| p2_reg | input | 8 | Current high-port register value |
| req_take | output | 1 | Request inputs are sampled at the end of this clock |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_out | output | 8 | Low port drive value (address low byte or write data) |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value |
| hi_out | output | 8 | High port drive value |
| rdata | output | 8 | Last captured read byte |
| rdata_valid | output | 1 | One-clock pulse marking a new `rdata` |

## Verification
The fetch that straddles the on-chip limit is the hardest case to reach. Its first half must stay quiet while its second half runs a full external read. The bench resets with on-chip code enabled, drops `int_rom_en` right after reset, and fetches at 8191. This shows both the per-half routing and that the mode was latched. The capture clock is confirmed by putting the expected byte on `lo_in` only in the single clock before the strobe rises, and a filler byte in every other clock.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    localparam int unsigned AW       = 16;
    localparam int unsigned DW       = 8;
    localparam int unsigned STATES   = 6;
    // Phase is a single bit; the timer relies on two phases per state.
    localparam int unsigned PHASES   = 2;
    localparam int unsigned CYC_LEN  = STATES * PHASES;
    localparam int unsigned HALF_LEN = CYC_LEN / 2;
    localparam int unsigned POS_W    = $clog2(CYC_LEN);

    typedef logic [POS_W-1:0] pos_t;

    // Clock positions inside a machine cycle (or inside one half of it).
    localparam pos_t POS_LAST      = pos_t'(CYC_LEN - 1);
    localparam pos_t POS_HALF      = pos_t'(HALF_LEN);
    localparam pos_t POS_HALF_LAST = pos_t'(HALF_LEN - 1);
    localparam pos_t POS_ALE_END   = pos_t'(1);
    localparam pos_t POS_ADDR_END  = pos_t'(2);
    localparam pos_t POS_PSEN_BEG  = pos_t'(3);
    localparam pos_t POS_WD_BEG    = pos_t'(4);
    localparam pos_t POS_XS_BEG    = pos_t'(5);
    localparam pos_t POS_XS_END    = pos_t'(10);

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_FETCH = 2'd1,
        K_READ  = 2'd2,
        K_WRITE = 2'd3
    } bus_kind_e;

    typedef struct packed {
        bus_kind_e         kind;
        logic              wide;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     p2v;
        logic [1:0]        ext;
    } cyc_t;

    typedef struct packed {
        logic              ale;
        logic              psen_n;
        logic              rd_n;
        logic              wr_n;
        logic              lo_oe;
        logic [DW-1:0]     lo_out;
        logic [DW-1:0]     hi_out;
    } pins_t;

    localparam pins_t PINS_RST = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                   lo_oe: 1'b0, lo_out: '0, hi_out: '0};

    localparam cyc_t CYC_RST = '{kind: K_IDLE, wide: 1'b0, addr: '0, wdata: '0,
                                 p2v: '0, ext: 2'b00};

    // Pin values for clock position pos of a machine cycle described by c.
    function automatic pins_t pins_at(input pos_t pos, input cyc_t c);
        pins_t         p;
        logic          half;
        pos_t          off;
        logic          dcyc;
        logic          xs;
        logic [AW-1:0] fa;
        p        = PINS_RST;
        p.hi_out = c.p2v;
        p.lo_out = c.addr[DW-1:0];
        half     = (pos >= POS_HALF);
        off      = half ? pos_t'(pos - POS_HALF) : pos;
        dcyc     = (c.kind == K_READ) || (c.kind == K_WRITE);
        xs       = (pos >= POS_XS_BEG) && (pos <= POS_XS_END);
        p.ale    = (off <= POS_ALE_END) && !(half && dcyc);
        fa       = c.addr + AW'(half);
        case (c.kind)
            K_FETCH: begin
                if (c.ext[half]) begin
                    p.hi_out = fa[AW-1:DW];
                    p.lo_out = fa[DW-1:0];
                    p.lo_oe  = (off <= POS_ADDR_END);
                    p.psen_n = !(off >= POS_PSEN_BEG);
                end
            end
            K_READ, K_WRITE: begin
                p.hi_out = c.wide ? c.addr[AW-1:DW] : c.p2v;
                p.lo_oe  = (pos <= POS_ADDR_END);
                p.rd_n   = !(xs && (c.kind == K_READ));
                p.wr_n   = !(xs && (c.kind == K_WRITE));
                if ((c.kind == K_WRITE) && (pos >= POS_WD_BEG)) begin
                    p.lo_oe  = 1'b1;
                    p.lo_out = c.wdata;
                end
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/mxb_timer.sv
module mxb_timer
    import mxb_pkg::*;
#(
    parameter int unsigned STATE_W = 4
) (
    input  logic clk,
    input  logic rst,
    output pos_t pos_q,
    output pos_t pos_nx,
    output logic wrap
);

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               phase;
    } tm_t;

    localparam logic [STATE_W-1:0] ST_LAST = STATE_W'(STATES - 1);
    localparam tm_t TM_RST = '{state: ST_LAST, phase: 1'b1};

    tm_t tm_q, tm_d;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.phase) begin
            tm_d.phase = 1'b0;
            tm_d.state = (tm_q.state == ST_LAST) ? '0 : tm_q.state + 1'b1;
        end else begin
            tm_d.phase = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tm_q <= TM_RST;
        else     tm_q <= tm_d;
    end

    assign pos_q  = pos_t'({tm_q.state, tm_q.phase});
    assign pos_nx = pos_t'({tm_d.state, tm_d.phase});
    assign wrap   = (pos_q == POS_LAST);

endmodule

// File: rtl/mxb_route.sv
module mxb_route
    import mxb_pkg::*;
#(
    parameter int unsigned INT_ROM_DEPTH = 8192
) (
    input  logic [AW-1:0] addr,
    input  logic          int_en,
    output logic [1:0]    ext
);

    localparam logic [AW:0] LIMIT = (AW+1)'(INT_ROM_DEPTH);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [AW:0] half_addr;
        assign half_addr = {1'b0, addr} + (AW+1)'(h);
        assign ext[h]    = !int_en || (half_addr >= LIMIT);
    end

endmodule

// File: rtl/mxb_sequencer.sv
module mxb_sequencer
    import mxb_pkg::*;
#(
    parameter int unsigned INT_ROM_DEPTH = 8192,
    parameter int unsigned STATE_W       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          int_rom_en,
    input  logic [1:0]    req_kind,
    input  logic          req_wide,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] p2_reg,
    output logic          req_take,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] lo_out,
    output logic          lo_oe,
    input  logic [DW-1:0] lo_in,
    output logic [DW-1:0] hi_out,
    output logic [DW-1:0] rdata,
    output logic          rdata_valid
);

    typedef struct packed {
        cyc_t          cyc;
        pins_t         pins;
        logic          int_en;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } seq_t;

    localparam seq_t SEQ_RST = '{cyc: CYC_RST, pins: PINS_RST, int_en: 1'b0,
                                 rdata: '0, rvalid: 1'b0};

    seq_t       seq_q, seq_d;
    pos_t       pos_q, pos_nx;
    logic       wrap;
    logic [1:0] req_ext;
    logic       cap_fetch, cap_read;

    mxb_timer #(.STATE_W(STATE_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .pos_q  (pos_q),
        .pos_nx (pos_nx),
        .wrap   (wrap)
    );

    mxb_route #(.INT_ROM_DEPTH(INT_ROM_DEPTH)) u_route (
        .addr   (req_addr),
        .int_en (seq_q.int_en),
        .ext    (req_ext)
    );

    // Capture points: last clock of each strobe's low window.
    assign cap_fetch = (seq_q.cyc.kind == K_FETCH) &&
                       (((pos_q == POS_HALF_LAST) && seq_q.cyc.ext[0]) ||
                        ((pos_q == POS_LAST)      && seq_q.cyc.ext[1]));
    assign cap_read  = (seq_q.cyc.kind == K_READ) && (pos_q == POS_XS_END);

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        if (wrap) begin
            seq_d.cyc.kind  = bus_kind_e'(req_kind);
            seq_d.cyc.wide  = req_wide;
            seq_d.cyc.addr  = req_addr;
            seq_d.cyc.wdata = req_wdata;
            seq_d.cyc.p2v   = p2_reg;
            seq_d.cyc.ext   = req_ext;
        end
        seq_d.pins = pins_at(pos_nx, seq_d.cyc);
        if (cap_fetch || cap_read) begin
            seq_d.rdata  = lo_in;
            seq_d.rvalid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q        <= SEQ_RST;
            seq_q.int_en <= int_rom_en;
        end else begin
            seq_q        <= seq_d;
        end
    end

    assign req_take    = wrap;
    assign ale         = seq_q.pins.ale;
    assign psen_n      = seq_q.pins.psen_n;
    assign rd_n        = seq_q.pins.rd_n;
    assign wr_n        = seq_q.pins.wr_n;
    assign lo_out      = seq_q.pins.lo_out;
    assign lo_oe       = seq_q.pins.lo_oe;
    assign hi_out      = seq_q.pins.hi_out;
    assign rdata       = seq_q.rdata;
    assign rdata_valid = seq_q.rvalid;

endmodule

// File: rtl/mxb_checker.sv
module mxb_checker (
    input logic clk,
    input logic rst,
    input logic req_take,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic lo_oe
);

    // R3
    psen_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> (rd_n && wr_n));

    // R6
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R4
    psen_release_chk: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !lo_oe);

    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !lo_oe);

    // R7
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> lo_oe);

    // R1
    ale_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale ##1 !ale);

    // R6
    rd_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n) |-> ($past(ale, 4) && !$past(ale, 3)));

    // R6
    wr_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_n) |-> ($past(ale, 4) && !$past(ale, 3)));

    // R6
    ale_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_n) || $rose(wr_n)) |=> $rose(ale));

    // R10
    take_single_chk: assert property (@(posedge clk) disable iff (rst)
        req_take |=> !req_take);

endmodule

bind mxb_sequencer mxb_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_take (req_take),
    .ale      (ale),
    .psen_n   (psen_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .lo_oe    (lo_oe)
);

// File: tb/sim_mxb_sequencer.sv
module sim_mxb_sequencer;

    localparam int CLK_PER = 10;
    localparam int NS      = 13;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        int_rom_en = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  p2_reg = '0;
    logic [7:0]  lo_in = 8'h5A;
    logic        req_take, ale, psen_n, rd_n, wr_n, lo_oe, rdata_valid;
    logic [7:0]  lo_out, hi_out, rdata;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [NS-1:0] a_ale, a_psen, a_rd, a_wr, a_oe, a_rv, a_take;
    logic [7:0]    a_lo [NS];
    logic [7:0]    a_hi [NS];
    logic [7:0]    a_rdat [NS];

    always #(CLK_PER/2) clk = ~clk;

    mxb_sequencer u0 (
        .clk(clk), .rst(rst), .int_rom_en(int_rom_en), .req_kind(req_kind),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .p2_reg(p2_reg), .req_take(req_take), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
        .hi_out(hi_out), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic en);
        rst = 1'b1;
        int_rom_en = en;
        req_kind = 2'd0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(ale == 1'b0 && psen_n && rd_n && wr_n && !lo_oe && !rdata_valid,
              "R11", "reset pins", {26'd0, ale, psen_n, rd_n, wr_n, lo_oe, rdata_valid},
              32'b011100);
        rst = 1'b0;
        int_rom_en = ~en;   // R9: later changes must be ignored
    endtask

    // Drive one request and sample positions 0..11 plus position 0 of the next cycle.
    task automatic run_cycle(input logic [1:0] kind, input logic wide,
                             input logic [15:0] addr, input logic [7:0] wd,
                             input logic [7:0] p2, input int cap0, input int cap1,
                             input logic [7:0] v0, input logic [7:0] v1);
        while (!req_take) @(negedge clk);
        req_kind = kind; req_wide = wide; req_addr = addr;
        req_wdata = wd; p2_reg = p2;
        for (int c = 0; c < NS; c++) begin
            @(negedge clk);
            if (c == 0) begin
                // R10: mid-cycle changes to the request have no effect
                req_kind = 2'd0; req_addr = 16'hFFFF; req_wide = ~wide; req_wdata = 8'h00;
            end
            a_ale[c] = ale; a_psen[c] = psen_n; a_rd[c] = rd_n; a_wr[c] = wr_n;
            a_oe[c] = lo_oe; a_rv[c] = rdata_valid; a_take[c] = req_take;
            a_lo[c] = lo_out; a_hi[c] = hi_out; a_rdat[c] = rdata;
            lo_in = (c == cap0) ? v0 : ((c == cap1) ? v1 : 8'h5A);
        end
    endtask

    task automatic check_cycle(input logic [1:0] kind, input logic wide,
                               input logic [15:0] addr, input logic [7:0] wd,
                               input logic [7:0] p2, input logic ext0, input logic ext1,
                               input string tag);
        logic [NS-1:0] e_ale, e_psen, e_rd, e_wr, e_oe, e_rv, e_take;
        logic [7:0]    e_lo [NS];
        logic [7:0]    e_hi [NS];
        logic [7:0]    e_rdat [NS];
        bit            lo_ok, hi_ok, rd_ok;
        logic          dcyc;
        dcyc = (kind == 2'd2) || (kind == 2'd3);
        for (int c = 0; c < NS; c++) begin
            int            off;
            int            h;
            logic          ex;
            logic [15:0]   fa;
            h  = (c >= 6 && c < 12) ? 1 : 0;
            off = (c >= 12) ? 0 : c - 6 * h;
            ex = h ? ext1 : ext0;
            fa = addr + 16'(h);
            e_ale[c] = (off <= 1) && !(h == 1 && dcyc && c < 12);
            e_psen[c] = 1'b1; e_rd[c] = 1'b1; e_wr[c] = 1'b1; e_oe[c] = 1'b0;
            e_rv[c] = 1'b0; e_take[c] = (c == 11);
            e_lo[c] = 8'h00; e_hi[c] = p2; e_rdat[c] = 8'h00;
            if (c < 12) begin
                if (kind == 2'd1 && ex) begin
                    e_psen[c] = !(off >= 3);
                    e_oe[c] = (off <= 2);
                    e_lo[c] = fa[7:0];
                    e_hi[c] = fa[15:8];
                end
                if (dcyc) begin
                    e_hi[c] = wide ? addr[15:8] : p2;
                    e_oe[c] = (c <= 2) || (kind == 2'd3 && c >= 4);
                    e_lo[c] = (c <= 2) ? addr[7:0] : wd;
                    e_rd[c] = !(kind == 2'd2 && c >= 5 && c <= 10);
                    e_wr[c] = !(kind == 2'd3 && c >= 5 && c <= 10);
                end
            end
        end
        if (kind == 2'd1 && ext0) begin e_rv[6] = 1'b1; e_rdat[6] = code_byte(addr); end
        if (kind == 2'd1 && ext1) begin e_rv[12] = 1'b1; e_rdat[12] = code_byte(addr + 16'd1); end
        if (kind == 2'd2) begin e_rv[11] = 1'b1; e_rdat[11] = addr[7:0] + 8'h3C; end

        lo_ok = 1'b1; hi_ok = 1'b1; rd_ok = 1'b1;
        for (int c = 0; c < NS; c++) begin
            if (e_oe[c] && a_lo[c] != e_lo[c]) lo_ok = 1'b0;
            if (c < 12 && a_hi[c] != e_hi[c]) hi_ok = 1'b0;
            if (e_rv[c] && a_rdat[c] != e_rdat[c]) rd_ok = 1'b0;
        end
        check(a_ale == e_ale, dcyc ? "R2" : "R1", {tag, " ale"}, 32'(a_ale), 32'(e_ale));
        check(a_psen == e_psen, (kind == 2'd1) ? "R3 R9" : "R3", {tag, " psen_n"},
              32'(a_psen), 32'(e_psen));
        check(a_rd == e_rd && a_wr == e_wr, "R6", {tag, " rd_n/wr_n"},
              {16'(a_rd), 16'(a_wr)}, {16'(e_rd), 16'(e_wr)});
        check(a_oe == e_oe, (kind == 2'd3) ? "R7" : "R4", {tag, " lo_oe"},
              32'(a_oe), 32'(e_oe));
        check(lo_ok, (kind == 2'd3) ? "R7" : "R4", {tag, " lo_out"}, 32'(lo_ok), 32'd1);
        check(hi_ok, "R5", {tag, " hi_out"}, 32'(hi_ok), 32'd1);
        check(a_rv == e_rv, "R8", {tag, " rdata_valid"}, 32'(a_rv), 32'(e_rv));
        check(rd_ok, "R8", {tag, " rdata"}, 32'(rd_ok), 32'd1);
        check(a_take == e_take, "R10", {tag, " req_take"}, 32'(a_take), 32'(e_take));
    endtask

    task automatic t_idle();
        run_cycle(2'd0, 1'b0, 16'h4321, 8'h00, 8'h77, -1, -1, 8'h00, 8'h00);
        check_cycle(2'd0, 1'b0, 16'h4321, 8'h00, 8'h77, 1'b0, 1'b0, "R1 idle");
    endtask

    task automatic t_fetch(input logic [15:0] a, input logic ext0, input logic ext1,
                           input string tag);
        run_cycle(2'd1, 1'b0, a, 8'h00, 8'h3E, ext0 ? 5 : -1, ext1 ? 11 : -1,
                  code_byte(a), code_byte(a + 16'd1));
        check_cycle(2'd1, 1'b0, a, 8'h00, 8'h3E, ext0, ext1, tag);
    endtask

    task automatic t_read(input logic wide, input logic [15:0] a, input string tag);
        run_cycle(2'd2, wide, a, 8'h00, 8'hC3, 10, -1, a[7:0] + 8'h3C, 8'h00);
        check_cycle(2'd2, wide, a, 8'h00, 8'hC3, 1'b0, 1'b0, tag);
    endtask

    task automatic t_write(input logic wide, input logic [15:0] a, input logic [7:0] d,
                           input string tag);
        run_cycle(2'd3, wide, a, d, 8'h96, -1, -1, 8'h00, 8'h00);
        check_cycle(2'd3, wide, a, d, 8'h96, 1'b0, 1'b0, tag);
    endtask

    initial begin
        do_reset(1'b0);                       // all code external
        t_idle();
        t_fetch(16'h1234, 1'b1, 1'b1, "R3 fetch ext");
        t_fetch(16'h00FF, 1'b1, 1'b1, "R3 fetch carry");
        t_read(1'b1, 16'hBEEF, "R6 read wide");
        t_read(1'b0, 16'h5510, "R5 read narrow");
        t_write(1'b1, 16'h8A01, 8'h69, "R7 write wide");
        t_write(1'b0, 16'h0042, 8'hD2, "R7 write narrow");
        do_reset(1'b1);                       // on-chip code below the limit
        t_fetch(16'h0100, 1'b0, 1'b0, "R9 internal");
        t_fetch(16'h1FFF, 1'b0, 1'b1, "R9 boundary");
        t_fetch(16'h3000, 1'b1, 1'b1, "R9 above limit");
        t_read(1'b1, 16'h0010, "R9 data unaffected");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule